// File: doc/BRIEF.md
# Single-Frame Ethernet Receive Buffer

This block takes one incoming Ethernet frame from a byte stream, classifies it at the end of the frame and, when the frame is good and acceptance is enabled, keeps it in on-chip RAM. A host reads the frame back through a 16-bit word window. The window holds a status word, a length word and the frame bytes in packed 16-bit words. Each byte stream beat carries one byte. The first byte of a frame is flagged as start. The last byte is flagged as end, and the length-error and CRC-error indications travel with that last byte.

A good frame raises a pending receive event and, when enabled, an interrupt. The host reads the event through an event queue register, which clears both the event and the interrupt. The host then reads the frame words. Reading the word that holds the final byte frees the buffer for the next frame. A frame that arrives while the buffer still holds an unread frame is discarded, and a missed-frame flag is set.

Top module: `eth_rx_frame_store`

## Requirements
- R1: A frame is stored (buffer held, event pending) only when its end beat has no CRC error and no length-error flag, its byte count including CRC lies in MIN_LEN..MAX_LEN, and cfg_accept_good is 1. Any other frame leaves the buffer free and no event pending.
- R2: The length word at 0x0402 reads the stored byte count. With cfg_keep_crc=1 this is the whole frame including the 4 CRC bytes. With cfg_keep_crc=0 it is the frame size minus 4. The length word changes only when a frame is accepted.
- R3: Frame byte k is read at word offset 0x0404 + 2*(k/2). An even k is in bits 7:0 and an odd k is in bits 15:8. A byte position at or beyond the reported length reads as zero, which covers the pad of an odd final byte and the stripped CRC bytes.
- R4: The status word at 0x0400 is rewritten at the end of every frame received while the buffer is free. Its fields are: bits 5:0 = 0x04, bit 8 good frame, bit 10 CRC error, bit 11 shorter than MIN_LEN, bit 12 longer than MAX_LEN, bit 13 length-error flag, and all other bits 0 except bit 9.
- R5: irq rises on the clock edge that accepts a frame if cfg_good_irq_en is 1. It stays low for an accepted frame if cfg_good_irq_en is 0.
- R6: A read of the event queue at 0x0120 returns the status word while an event is pending and 0 otherwise. The read clears the pending event and drops irq.
- R7: A frame that starts while a frame is held is discarded. The held length and data are unchanged, and status bit 9 (missed) becomes 1. Bit 9 survives later status rewrites and is cleared only by an event queue read.
- R8: A host read of the data word that contains the final stored byte frees the buffer, so the next good frame is accepted.
- R9: host_rdata presents the value for a read in the cycle after host_rd. Odd addresses and addresses outside the registers and the data window read 0.
- R10: After reset irq is 0, the status, length and event queue registers read 0, and the buffer is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A byte is present on rx_byte |
| rx_byte | input | 8 | Received frame byte |
| rx_sof | input | 1 | Current byte is the first of a frame |
| rx_eof | input | 1 | Current byte is the last of a frame |
| rx_len_err | input | 1 | Length error for the frame, valid with rx_eof |
| rx_crc_err | input | 1 | CRC error for the frame, valid with rx_eof |
| cfg_accept_good | input | 1 | Keep good frames |
| cfg_good_irq_en | input | 1 | Interrupt on accepted good frame |
| cfg_keep_crc | input | 1 | Keep CRC bytes in buffer and length |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 16 | Host byte address of the 16-bit word |
| host_rdata | output | 16 | Read data, valid the cycle after host_rd |
| irq | output | 1 | Good-frame interrupt |

## Verification
The bench builds the block with MIN_LEN=8 and MAX_LEN=20, which gives a ten-word buffer. With these values the shortest legal frame, the longest legal frame, one-byte-short and one-byte-long frames, and a counter saturating on a 25-byte frame are all reached in a few dozen cycles each. Because the buffer is this small, every word of the data window can be read back after each accepted frame, including the zeroed positions past the reported length. The same setup covers the hold, drop and release sequence for missed frames.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

  localparam logic [15:0] ADDR_ISQ  = 16'h0120;
  localparam logic [15:0] ADDR_STAT = 16'h0400;
  localparam logic [15:0] ADDR_LEN  = 16'h0402;
  localparam logic [15:0] ADDR_DATA = 16'h0404;

  localparam logic [5:0] EVT_CODE = 6'h04;
  localparam int ST_MISS = 9;

  typedef enum logic [0:0] {SEL_REG, SEL_DATA} rd_sel_e;

  // status word from frame classification (missed bit left clear)
  function automatic logic [15:0] make_status(input logic good, input logic crc,
                                              input logic shrt, input logic lng,
                                              input logic lflag);
    return {2'b00, lflag, lng, shrt, crc, 1'b0, good, 2'b00, EVT_CODE};
  endfunction

  function automatic logic [15:0] kept_len(input logic [15:0] total, input logic keep);
    return keep ? total : total - 16'd4;
  endfunction

  function automatic logic byte_live(input logic [15:0] idx, input logic [15:0] len);
    return idx < len;
  endfunction

endpackage

// File: rtl/rxfb_word_ram.sv
module rxfb_word_ram #(
  parameter int WORDS = 759,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wlane,
  input  logic [7:0]    wbyte,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      if (wlane) mem[waddr][15:8] <= wbyte;
      else       mem[waddr][7:0]  <= wbyte;
    end
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxfb_rx_ctrl.sv
module rxfb_rx_ctrl
  import rxfb_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int AW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_len_err,
  input  logic          rx_crc_err,
  input  logic          cfg_accept_good,
  input  logic          cfg_good_irq_en,
  input  logic          cfg_keep_crc,
  input  logic          isq_rd,
  input  logic          buf_release,
  output logic          wr_en,
  output logic [AW-1:0] wr_word,
  output logic          wr_lane,
  output logic          held,
  output logic          pending,
  output logic          irq,
  output logic [15:0]   status_q,
  output logic [15:0]   len_q,
  output logic          frame_done,
  output logic          frame_accept,
  output logic          drop_busy
);
  localparam logic [15:0] MINL  = 16'(MIN_LEN);
  localparam logic [15:0] MAXL  = 16'(MAX_LEN);
  localparam logic [15:0] MAXP1 = 16'(MAX_LEN + 1);

  logic [15:0] cnt_q, cur_idx, total, status_d;
  logic in_frame_q, skip_q, take, busy_frame, eof_now;
  logic is_short, is_long, good;

  always_comb begin
    take       = rx_valid && (rx_sof || in_frame_q);
    busy_frame = rx_sof ? held : skip_q;
    cur_idx    = rx_sof ? 16'd0 : cnt_q;
    total      = (cur_idx >= MAXP1) ? MAXP1 : cur_idx + 16'd1;
    eof_now    = take && rx_eof;
    is_short   = total < MINL;
    is_long    = total > MAXL;
    good       = !rx_crc_err && !rx_len_err && !is_short && !is_long;
    frame_done   = eof_now && !busy_frame;
    drop_busy    = eof_now && busy_frame;
    frame_accept = frame_done && good && cfg_accept_good;
    wr_en   = take && !busy_frame && (cur_idx < MAXL);
    wr_word = cur_idx[AW:1];
    wr_lane = cur_idx[0];
    status_d = frame_done ? make_status(good, rx_crc_err, is_short, is_long, rx_len_err)
                          : status_q;
    status_d[ST_MISS] = drop_busy ? 1'b1 : (isq_rd ? 1'b0 : status_q[ST_MISS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      skip_q     <= 1'b0;
      held       <= 1'b0;
      pending    <= 1'b0;
      irq        <= 1'b0;
      status_q   <= '0;
      len_q      <= '0;
    end else begin
      if (take) begin
        cnt_q      <= total;
        in_frame_q <= !rx_eof;
        if (rx_sof) skip_q <= held;
      end
      if (frame_accept) begin
        held  <= 1'b1;
        len_q <= kept_len(total, cfg_keep_crc);
      end else if (buf_release) begin
        held <= 1'b0;
      end
      if (frame_accept)  pending <= 1'b1;
      else if (isq_rd)   pending <= 1'b0;
      if (frame_accept)  irq <= cfg_good_irq_en;
      else if (isq_rd)   irq <= 1'b0;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/rxfb_host_port.sv
module rxfb_host_port
  import rxfb_pkg::*;
#(
  parameter int WORDS = 759,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic [15:0]   host_addr,
  input  logic [15:0]   status_q,
  input  logic [15:0]   len_q,
  input  logic          pending,
  input  logic          held,
  input  logic [15:0]   ram_rdata,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic [15:0]   host_rdata,
  output logic          isq_rd,
  output logic          buf_release
);
  localparam logic [15:0] SPAN = 16'(2 * WORDS);

  logic [15:0]   off, reg_val, reg_q, len_snap_q, lo_idx;
  logic [AW-1:0] widx, widx_q;
  logic          is_data;
  rd_sel_e       sel_q;

  always_comb begin
    off     = host_addr - ADDR_DATA;
    is_data = !host_addr[0] && (host_addr >= ADDR_DATA) && (off < SPAN);
    widx    = off[AW:1];
    isq_rd  = host_rd && (host_addr == ADDR_ISQ);
    ram_re  = host_rd && is_data;
    ram_raddr   = widx;
    buf_release = host_rd && is_data && held &&
                  (((16'(widx)) << 1) + 16'd2 >= len_q);
    case (host_addr)
      ADDR_ISQ:  reg_val = pending ? status_q : 16'd0;
      ADDR_STAT: reg_val = status_q;
      ADDR_LEN:  reg_val = len_q;
      default:   reg_val = 16'd0;
    endcase
    lo_idx = (16'(widx_q)) << 1;
    if (sel_q == SEL_DATA)
      host_rdata = {byte_live(lo_idx + 16'd1, len_snap_q) ? ram_rdata[15:8] : 8'd0,
                    byte_live(lo_idx, len_snap_q)         ? ram_rdata[7:0]  : 8'd0};
    else
      host_rdata = reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= SEL_REG;
      reg_q      <= '0;
      widx_q     <= '0;
      len_snap_q <= '0;
    end else if (host_rd) begin
      sel_q      <= is_data ? SEL_DATA : SEL_REG;
      reg_q      <= reg_val;
      widx_q     <= widx;
      len_snap_q <= len_q;
    end
  end
endmodule

// File: rtl/eth_rx_frame_store.sv
module eth_rx_frame_store #(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_len_err,
  input  logic        rx_crc_err,
  input  logic        cfg_accept_good,
  input  logic        cfg_good_irq_en,
  input  logic        cfg_keep_crc,
  input  logic        host_rd,
  input  logic [15:0] host_addr,
  output logic [15:0] host_rdata,
  output logic        irq
);
  localparam int WORDS = (MAX_LEN + 1) / 2;
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic          wr_en, wr_lane, held, pending, ram_re;
  logic          isq_rd, buf_release, frame_done, frame_accept, drop_busy;
  logic [AW-1:0] wr_word, ram_raddr;
  logic [15:0]   status_q, len_q, ram_rdata;

  rxfb_rx_ctrl #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .AW(AW)) u_ctrl (
    .clk, .rst_n, .rx_valid, .rx_sof, .rx_eof, .rx_len_err, .rx_crc_err,
    .cfg_accept_good, .cfg_good_irq_en, .cfg_keep_crc,
    .isq_rd, .buf_release, .wr_en, .wr_word, .wr_lane, .held, .pending, .irq,
    .status_q, .len_q, .frame_done, .frame_accept, .drop_busy
  );

  rxfb_word_ram #(.WORDS(WORDS), .AW(AW)) u_ram (
    .clk, .we(wr_en), .waddr(wr_word), .wlane(wr_lane), .wbyte(rx_byte),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  rxfb_host_port #(.WORDS(WORDS), .AW(AW)) u_host (
    .clk, .rst_n, .host_rd, .host_addr, .status_q, .len_q, .pending, .held,
    .ram_rdata, .ram_re, .ram_raddr, .host_rdata, .isq_rd, .buf_release
  );
endmodule

// File: rtl/rxfb_checker.sv
module rxfb_checker #(
  parameter int MAX_LEN = 1518
) (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_accept,
  input logic        drop_busy,
  input logic        held,
  input logic        irq,
  input logic        isq_rd,
  input logic        buf_release,
  input logic        cfg_good_irq_en,
  input logic [15:0] status_q,
  input logic [15:0] len_q
);
  AST_ACCEPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |=> held); // R1
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (len_q <= 16'(MAX_LEN))); // R2
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_accept && cfg_good_irq_en)); // R5
  AST_ISQ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (isq_rd && !frame_accept) |=> !irq); // R6
  AST_DROP_MARKS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_busy |=> status_q[9]); // R7
  AST_HELD_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(len_q)); // R7
  AST_HELD_FALLS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> $past(buf_release)); // R8
endmodule

bind eth_rx_frame_store rxfb_checker #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk, .rst_n, .frame_accept, .drop_busy, .held, .irq, .isq_rd, .buf_release,
  .cfg_good_irq_en, .status_q, .len_q
);

// File: tb/eth_rx_frame_store_test.sv
`timescale 1ns/100ps
module eth_rx_frame_store_test;
  localparam int MINL = 8;
  localparam int MAXL = 20;
  localparam int NW   = (MAXL + 1) / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_len_err = 0, rx_crc_err = 0;
  logic [7:0] rx_byte = 0;
  logic cfg_accept_good = 1, cfg_good_irq_en = 1, cfg_keep_crc = 1;
  logic host_rd = 0;
  logic [15:0] host_addr = 0;
  logic [15:0] host_rdata;
  logic irq;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eth_rx_frame_store #(.MIN_LEN(MINL), .MAX_LEN(MAXL)) uut (
    .clk, .rst_n, .rx_valid, .rx_byte, .rx_sof, .rx_eof, .rx_len_err, .rx_crc_err,
    .cfg_accept_good, .cfg_good_irq_en, .cfg_keep_crc, .host_rd, .host_addr,
    .host_rdata, .irq
  );

  // {length[7:0], crc_err, len_err, accept, keep_crc, irq_en}
  localparam logic [12:0] VEC [10] = '{
    {8'd12, 5'b00111}, {8'd13, 5'b00101}, {8'd8,  5'b00110}, {8'd20, 5'b00101},
    {8'd7,  5'b00111}, {8'd21, 5'b00111}, {8'd12, 5'b10111}, {8'd12, 5'b01111},
    {8'd12, 5'b00011}, {8'd25, 5'b00101}
  };

  function automatic logic [7:0] pat(int s, int k);
    return 8'((s * 37 + k * 5 + 1) & 255);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(int s, int n, logic crc, logic lerr);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_byte = pat(s, k);
      rx_sof = (k == 0); rx_eof = (k == n - 1);
      rx_crc_err = (k == n - 1) ? crc : 1'b0;
      rx_len_err = (k == n - 1) ? lerr : 1'b0;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_err = 0; rx_len_err = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    @(negedge clk);
    host_rd = 0;
    d = host_rdata;
  endtask

  function automatic logic [15:0] exp_word(int s, int w, int elen);
    logic [7:0] lo, hi;
    lo = (2 * w < elen) ? pat(s, 2 * w) : 8'd0;
    hi = (2 * w + 1 < elen) ? pat(s, 2 * w + 1) : 8'd0;
    return {hi, lo};
  endfunction

  task automatic read_words(int s, int elen, int from);
    logic [15:0] d;
    for (int w = from; w < NW; w++) begin
      rd(16'h0404 + 16'(2 * w), d);
      check("R3 data word", d, exp_word(s, w, elen));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq", 16'(irq), 16'd0);
    rd(16'h0400, d); check("R10 status", d, 16'h0000);
    rd(16'h0402, d); check("R10 length", d, 16'h0000);
    rd(16'h0120, d); check("R10 event queue", d, 16'h0000);

    for (int i = 0; i < 10; i++) begin
      int n;
      logic crc, lerr, acc_en, keep, ien, good, acc;
      int elen;
      n = int'(VEC[i][12:5]);
      {crc, lerr, acc_en, keep, ien} = VEC[i][4:0];
      cfg_accept_good = acc_en; cfg_keep_crc = keep; cfg_good_irq_en = ien;
      good = !crc && !lerr && (n >= MINL) && (n <= MAXL);
      acc  = good && acc_en;
      st = 16'h0004 | (16'(good) << 8) | (16'(crc) << 10) | (16'(n < MINL) << 11)
         | (16'(n > MAXL) << 12) | (16'(lerr) << 13);
      elen = keep ? n : n - 4;
      send(i, n, crc, lerr);
      check("R5 irq after frame", 16'(irq), 16'(acc && ien));
      rd(16'h0400, d); check("R4 status", d, st);
      if (acc) begin rd(16'h0402, d); check("R2 length", d, 16'(elen)); end
      rd(16'h0120, d);
      check("R1 accept decision", 16'(d[8]), 16'(acc));
      check("R6 event queue", d, acc ? st : 16'h0000);
      @(negedge clk);
      check("R6 irq cleared", 16'(irq), 16'd0);
      if (acc) read_words(i, elen, 0);
    end

    // R9 unmapped and odd addresses
    rd(16'h0200, d); check("R9 unmapped", d, 16'h0000);
    rd(16'h0401, d); check("R9 odd address", d, 16'h0000);
    rd(16'h0404 + 16'(2 * NW), d); check("R9 past window", d, 16'h0000);

    // R7 drop while held, R8 release
    cfg_accept_good = 1; cfg_keep_crc = 1; cfg_good_irq_en = 1;
    send(50, 10, 0, 0);
    send(60, 12, 0, 0);
    rd(16'h0400, d); check("R7 missed flag", d, 16'h0304);
    rd(16'h0402, d); check("R7 length kept", d, 16'd10);
    rd(16'h0404, d); check("R7 data kept", d, exp_word(50, 0, 10));
    rd(16'h0120, d); check("R6 event with missed", d, 16'h0304);
    rd(16'h0400, d); check("R7 missed cleared", d, 16'h0104);
    rd(16'h0120, d); check("R6 no event pending", d, 16'h0000);
    read_words(50, 10, 1);
    send(70, 9, 0, 0);
    check("R8 irq after release", 16'(irq), 16'd1);
    rd(16'h0402, d); check("R8 length new frame", d, 16'd9);
    rd(16'h040C, d); check("R3 odd pad", d, {8'd0, pat(70, 8)});
    rd(16'h0120, d); check("R8 event", d, 16'h0104);
    read_words(70, 9, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule